// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a memory-mapped trace sink. Trace words of 32 bits arrive on a streaming input. While capture is enabled, each one is written into an internal circular RAM, and the write pointer wraps modulo the RAM depth. Once the pointer has wrapped, a full flag shows that the oldest valid word now sits at the write pointer.

Capture can end in three ways:
- Software clears the enable bit.
- A trigger pulse has arrived and a programmed number of further words has been stored, when stop-on-trigger is selected.
- A manual flush has completed, when stop-on-flush is selected.

A flush pads the stream with zero words until the write pointer reaches a four-word frame boundary, when formatting is enabled. The flush-request bit stays set until the flush is done. Software polls a stopped bit before it dumps the RAM.

The RAM is reached through two auto-incrementing data windows on a simple register bus. One window reads at the read pointer and the other writes at the write pointer. Both pointers can also be written directly.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset, all of these read 0: the control register (0x020), both pointers (0x014, 0x018), the status register (0x00C), the trigger count (0x01C) and the flush control register (0x304). The depth register (0x004) reads the RAM depth. Flush status bit 1 (0x300) reads 1.
- R2: While control bit 0 is 1 and capture has not stopped, every cycle with `trace_valid` high stores `trace_data` at the write pointer, and the pointer then advances modulo the depth. While control bit 0 is 0, trace words are not stored and the pointer does not move.
- R3: Status bit 0 (full) becomes 1 when a store moves the write pointer from depth-1 to 0. Writing a 1 to control bit 0 clears it.
- R4: A bus read of 0x010 returns the RAM word at the read pointer and advances the pointer modulo the depth. Register 0x014 can be written at any time.
- R5: While control bit 0 is 0, a bus write to 0x024 stores the data at the write pointer and advances it. While control bit 0 is 1, a write to the write pointer (0x018) has no effect.
- R6: With flush control bit 13 set, a trigger pulse during capture loads the trigger count N. The word in the trigger cycle is stored, exactly N more words are stored, and capture then stops.
- R7: A trigger pulse while capture is not running, or while an earlier trigger is still pending, is ignored. It neither starts nor restarts the post-trigger count.
- R8: Writing 1 to flush control bit 6 starts a flush. The bit reads 1 until the flush completes and then clears by itself. While it is 1, trace input is not stored. With formatting enabled (flush control bit 0) and capture running, zero words are stored until the write pointer is a multiple of 4.
- R9: With flush control bit 12 set, capture stops when a flush completes. Later trace words are not stored.
- R10: Flush status bit 1 reads 1 exactly when capture is not running, that is, when it is disabled or stopped. Writing 1 to control bit 0 restarts capture and clears the bit.
- R11: The trigger count register reads back the value written. Flush control reads back bits 0, 12 and 13 as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_valid | input | 1 | Trace word present this cycle |
| trace_data | input | DATA_W | Trace word |
| trig_pulse | input | 1 | Single-cycle trigger event |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |

## Verification
The bench places a trigger pulse while capture is disabled and a second one inside the post-trigger window. A design that accepted either pulse would stop too early or too late, and the final write pointer would be wrong. It starts a flush from a misaligned pointer while trace words are still arriving. A design that stored those words, padded with the wrong count, or failed to clear the request bit would show a wrong pointer or wrong dumped data. It also wraps the write pointer to check the full flag, and writes the write pointer while capture is on. A design that moved the pointer would corrupt the scoreboard dump.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int BUS_AW = 12;
  localparam logic [BUS_AW-1:0] OFS_DEPTH = 12'h004;
  localparam logic [BUS_AW-1:0] OFS_STAT  = 12'h00C;
  localparam logic [BUS_AW-1:0] OFS_RDATA = 12'h010;
  localparam logic [BUS_AW-1:0] OFS_RPTR  = 12'h014;
  localparam logic [BUS_AW-1:0] OFS_WPTR  = 12'h018;
  localparam logic [BUS_AW-1:0] OFS_TCNT  = 12'h01C;
  localparam logic [BUS_AW-1:0] OFS_CTRL  = 12'h020;
  localparam logic [BUS_AW-1:0] OFS_WDATA = 12'h024;
  localparam logic [BUS_AW-1:0] OFS_FSTAT = 12'h300;
  localparam logic [BUS_AW-1:0] OFS_FCTRL = 12'h304;

  localparam int FC_FMT     = 0;
  localparam int FC_FLUSH   = 6;
  localparam int FC_STOPFL  = 12;
  localparam int FC_STOPTR  = 13;
  localparam int FS_STOPPED = 1;
  localparam int FRAME_LOG2 = 2;

  function automatic logic on_frame_edge(input logic [FRAME_LOG2-1:0] lsb);
    return lsb == '0;
  endfunction
endpackage

// File: rtl/trs_regs.sv
module trs_regs
  import trs_pkg::*;
#(
  parameter int TCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [TCNT_W-1:0] wdata,
  output logic              cap_en,
  output logic              fmt_en,
  output logic              stop_on_flush,
  output logic              stop_on_trig,
  output logic [TCNT_W-1:0] trig_count,
  output logic              en_set,
  output logic              flush_req
);
  logic wr_ctrl, wr_fctrl, wr_tcnt;
  assign wr_ctrl   = wr_en && (addr == OFS_CTRL);
  assign wr_fctrl  = wr_en && (addr == OFS_FCTRL);
  assign wr_tcnt   = wr_en && (addr == OFS_TCNT);
  assign en_set    = wr_ctrl && wdata[0];
  assign flush_req = wr_fctrl && wdata[FC_FLUSH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en        <= 1'b0;
      fmt_en        <= 1'b0;
      stop_on_flush <= 1'b0;
      stop_on_trig  <= 1'b0;
      trig_count    <= '0;
    end else begin
      if (wr_ctrl) cap_en <= wdata[0];
      if (wr_tcnt) trig_count <= wdata;
      if (wr_fctrl) begin
        fmt_en        <= wdata[FC_FMT];
        stop_on_flush <= wdata[FC_STOPFL];
        stop_on_trig  <= wdata[FC_STOPTR];
      end
    end
  end
endmodule

// File: rtl/trs_ram.sv
module trs_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];
endmodule

// File: rtl/trs_capture.sv
module trs_capture
  import trs_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int TCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              fmt_en,
  input  logic              stop_on_flush,
  input  logic              stop_on_trig,
  input  logic [TCNT_W-1:0] trig_count,
  input  logic              en_set,
  input  logic              flush_req,
  input  logic              trace_valid,
  input  logic [DW-1:0]     trace_data,
  input  logic              trig_pulse,
  input  logic              sw_push,
  input  logic [DW-1:0]     sw_data,
  input  logic              wptr_wr,
  input  logic              rptr_wr,
  input  logic [AW-1:0]     ptr_wdata,
  input  logic              rd_pop,
  output logic [AW-1:0]     wptr,
  output logic [AW-1:0]     rptr,
  output logic              full,
  output logic              flush_busy,
  output logic              running,
  output logic              ram_we,
  output logic [AW-1:0]     ram_waddr,
  output logic [DW-1:0]     ram_wdata
);
  logic              halted, trig_pending;
  logic [TCNT_W-1:0] post_cnt;

  // named internal events
  logic trig_done, pad_store, trace_store, sw_store, store;
  logic trig_accept, flush_done, wptr_load;

  assign trig_done   = trig_pending && stop_on_trig && (post_cnt == '0);
  assign running     = cap_en && !halted && !trig_done;
  assign pad_store   = flush_busy && running && fmt_en && !on_frame_edge(wptr[FRAME_LOG2-1:0]);
  assign trace_store = running && trace_valid && !flush_busy;
  assign sw_store    = sw_push && !cap_en;
  assign store       = pad_store || trace_store || sw_store;
  assign trig_accept = trig_pulse && running && !trig_pending && !en_set;
  assign flush_done  = flush_busy && !pad_store;
  assign wptr_load   = wptr_wr && !cap_en;

  assign ram_we    = store;
  assign ram_waddr = wptr;
  always_comb begin
    if (pad_store)        ram_wdata = '0;
    else if (trace_store) ram_wdata = trace_data;
    else                  ram_wdata = sw_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wptr_load)  wptr <= ptr_wdata;
      else if (store) wptr <= wptr + 1'b1;
      if (rptr_wr)     rptr <= ptr_wdata;
      else if (rd_pop) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full         <= 1'b0;
      halted       <= 1'b0;
      trig_pending <= 1'b0;
      post_cnt     <= '0;
      flush_busy   <= 1'b0;
    end else begin
      if (en_set)                                   full <= 1'b0;
      else if (store && (wptr == {AW{1'b1}}))       full <= 1'b1;

      if (en_set)                                   halted <= 1'b0;
      else if (trig_done)                           halted <= 1'b1;
      else if (flush_done && stop_on_flush && cap_en) halted <= 1'b1;

      if (en_set) begin
        trig_pending <= 1'b0;
        post_cnt     <= '0;
      end else if (trig_accept) begin
        trig_pending <= 1'b1;
        post_cnt     <= trig_count;
      end else if (trig_pending && trace_store && (post_cnt != '0)) begin
        post_cnt <= post_cnt - 1'b1;
      end

      if (flush_busy) begin
        if (flush_done) flush_busy <= 1'b0;
      end else if (flush_req) begin
        flush_busy <= 1'b1;
      end
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trace_store, pad_store, sw_store})); // R5
  AST_FULL_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (store && (wptr == {AW{1'b1}}) && !en_set) |=> full); // R3
  AST_HALT_FREEZES_WPTR: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && halted && !en_set) |=> $stable(wptr)); // R6
  AST_TRIG_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_done && !en_set) |=> !running); // R6
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pending && !en_set) |=> (post_cnt <= $past(post_cnt))); // R7
  AST_WPTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr_wr && cap_en && !store) |=> $stable(wptr)); // R5
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_busy && wptr[FRAME_LOG2-1:0] == '0) |=> !flush_busy); // R8
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
  import trs_pkg::*;
#(
  parameter int DEPTH_LOG2 = 8,
  parameter int DATA_W     = 32,
  parameter int TCNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_valid,
  input  logic [DATA_W-1:0] trace_data,
  input  logic              trig_pulse,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic              cap_en, fmt_en, stop_on_flush, stop_on_trig, en_set, flush_req;
  logic [TCNT_W-1:0] trig_count;
  logic [DEPTH_LOG2-1:0] wptr, rptr, ram_waddr;
  logic              full, flush_busy, running, ram_we;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;
  logic              wr_en, rd_en;

  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  trs_regs #(.TCNT_W(TCNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
    .wdata(bus_wdata[TCNT_W-1:0]), .cap_en(cap_en), .fmt_en(fmt_en),
    .stop_on_flush(stop_on_flush), .stop_on_trig(stop_on_trig),
    .trig_count(trig_count), .en_set(en_set), .flush_req(flush_req)
  );

  trs_capture #(.AW(DEPTH_LOG2), .DW(DATA_W), .TCNT_W(TCNT_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .fmt_en(fmt_en),
    .stop_on_flush(stop_on_flush), .stop_on_trig(stop_on_trig),
    .trig_count(trig_count), .en_set(en_set), .flush_req(flush_req),
    .trace_valid(trace_valid), .trace_data(trace_data), .trig_pulse(trig_pulse),
    .sw_push(wr_en && (bus_addr == OFS_WDATA)), .sw_data(bus_wdata),
    .wptr_wr(wr_en && (bus_addr == OFS_WPTR)),
    .rptr_wr(wr_en && (bus_addr == OFS_RPTR)),
    .ptr_wdata(bus_wdata[DEPTH_LOG2-1:0]),
    .rd_pop(rd_en && (bus_addr == OFS_RDATA)),
    .wptr(wptr), .rptr(rptr), .full(full), .flush_busy(flush_busy),
    .running(running), .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  trs_ram #(.AW(DEPTH_LOG2), .DW(DATA_W)) ram_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(rptr), .rdata(ram_rdata)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_DEPTH: bus_rdata = DATA_W'(DEPTH);
      OFS_STAT:  bus_rdata[0] = full;
      OFS_RDATA: bus_rdata = ram_rdata;
      OFS_RPTR:  bus_rdata = DATA_W'(rptr);
      OFS_WPTR:  bus_rdata = DATA_W'(wptr);
      OFS_TCNT:  bus_rdata = DATA_W'(trig_count);
      OFS_CTRL:  bus_rdata[0] = cap_en;
      OFS_FSTAT: bus_rdata[FS_STOPPED] = !running;
      OFS_FCTRL: begin
        bus_rdata[FC_FMT]    = fmt_en;
        bus_rdata[FC_FLUSH]  = flush_busy;
        bus_rdata[FC_STOPFL] = stop_on_flush;
        bus_rdata[FC_STOPTR] = stop_on_trig;
      end
      default: bus_rdata = '0;
    endcase
  end

  AST_RESET_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en) |-> !running); // R10
endmodule

// File: tb/trace_ring_sink_tb_top.sv
module trace_ring_sink_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOG2 = 4;
  localparam int DEPTH = 1 << LOG2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tv = 1'b0, tg = 1'b0, sel = 1'b0, wr = 1'b0;
  logic [31:0] td = '0, wdata = '0, rdata;
  logic [11:0] addr = '0;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_ring_sink #(.DEPTH_LOG2(LOG2)) dut_i (
    .clk(clk), .rst_n(rst_n), .trace_valid(tv), .trace_data(td), .trig_pulse(tg),
    .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); #1 sel = 0; wr = 0;
  endtask

  task automatic brd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 sel = 0;
  endtask

  task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    brd(a, v);
    chk(req, $sformatf("reg %h", a), v, exp);
  endtask

  // driver: sends a word and pushes it to the scoreboard when it should be stored
  task automatic send(input logic [31:0] d, input logic trig, input logic keep);
    @(negedge clk); tv = 1; td = d; tg = trig;
    @(posedge clk); #1 tv = 0; tg = 0;
    if (keep) exp_q.push_back(d);
  endtask

  // monitor: pops expected words and compares against dumped RAM contents
  task automatic drain(input int n, input string req);
    logic [31:0] v;
    for (int i = 0; i < n; i++) begin
      brd(12'h010, v);
      if (exp_q.size() == 0) chk(req, "scoreboard empty", v, 32'hDEAD_BEEF);
      else chk(req, $sformatf("dump word %0d", i), v, exp_q.pop_front());
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rchk("R1", 12'h004, DEPTH);
    rchk("R1", 12'h020, 0);
    rchk("R1", 12'h014, 0);
    rchk("R1", 12'h018, 0);
    rchk("R1", 12'h00C, 0);
    rchk("R1", 12'h01C, 0);
    rchk("R1", 12'h304, 0);
    rchk("R1", 12'h300, 32'h2);
    // R2/R7: disabled capture ignores words and triggers
    send(32'h1111_0000, 1, 0);
    send(32'h1111_0001, 0, 0);
    send(32'h1111_0002, 1, 0);
    rchk("R2", 12'h018, 0);
    // R5 software write window, R4 read window
    bwr(12'h024, 32'hA0A0_0000);
    bwr(12'h024, 32'hA0A0_0001);
    rchk("R5", 12'h018, 2);
    rchk("R4", 12'h010, 32'hA0A0_0000);
    rchk("R4", 12'h010, 32'hA0A0_0001);
    rchk("R4", 12'h014, 2);
    bwr(12'h018, 0);
    bwr(12'h01C, 5);
    rchk("R11", 12'h01C, 5);
    bwr(12'h304, 32'h2001);
    rchk("R11", 12'h304, 32'h2001);
    // enable
    bwr(12'h020, 1);
    rchk("R10", 12'h300, 0);
    bwr(12'h018, 7);
    rchk("R5", 12'h018, 0);
    for (int i = 0; i < 7; i++) send(32'hD000_0000 + i, 0, 1);
    rchk("R7", 12'h018, 7);
    // R6 trigger with count 5, R7 second trigger inside the window
    send(32'hD000_0007, 1, 1);
    for (int i = 8; i < 20; i++) send(32'hD000_0000 + i, (i == 10), (i <= 12));
    rchk("R6", 12'h018, 13);
    rchk("R10", 12'h300, 32'h2);
    rchk("R6", 12'h020, 1);
    bwr(12'h020, 0);
    rchk("R3", 12'h00C, 0);
    bwr(12'h014, 0);
    drain(13, "R2");
    // R8/R9 flush with padding and stop
    bwr(12'h018, 0);
    bwr(12'h304, 32'h1001);
    bwr(12'h020, 1);
    for (int i = 0; i < 6; i++) send(32'hF000_0000 + i, 0, 1);
    rchk("R2", 12'h018, 6);
    bwr(12'h304, 32'h1041);
    fork
      rchk("R8", 12'h304, 32'h1041);
      send(32'hBAD0_0001, 0, 0);
    join
    exp_q.push_back(0);
    exp_q.push_back(0);
    repeat (5) @(posedge clk);
    rchk("R8", 12'h304, 32'h1001);
    rchk("R8", 12'h018, 8);
    rchk("R9", 12'h300, 32'h2);
    send(32'hBAD0_0002, 0, 0);
    rchk("R9", 12'h018, 8);
    bwr(12'h020, 0);
    bwr(12'h014, 0);
    drain(8, "R8");
    // R3 wrap and full flag
    bwr(12'h304, 32'h0001);
    bwr(12'h018, 8);
    bwr(12'h020, 1);
    for (int i = 0; i < 8; i++) send(32'hC000_0000 + i, 0, 1);
    rchk("R3", 12'h018, 0);
    rchk("R3", 12'h00C, 1);
    bwr(12'h020, 1);
    rchk("R3", 12'h00C, 0);
    bwr(12'h020, 0);
    bwr(12'h014, 8);
    drain(8, "R3");
    rchk("R4", 12'h014, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule